// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block supplies the access address for a four-beat memory burst. A burst opens when either of two load strobes captures an external address. The upper address bits are then held at the captured value. The two low bits walk through a four-entry sequence that starts at the captured offset. A static order input chooses the walk. In linear order the offset counts upward modulo four. In interleaved order each offset is the starting offset XORed with the beat number.

Movement is gated by an active-low advance input, which is sampled on each rising clock edge. When advance is high the address holds, which suspends the burst. A load takes precedence over advance on the same edge. After four advances the sequence is back at its starting offset and repeats. Chip-select qualification, the storage array and the data paths belong to the surrounding logic.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets `addr_o` to zero and `beat_o` to zero.
- R2: On a rising edge where `load_a_i` or `load_b_i` is high (either one, or both), `addr_o` takes the value of `ext_addr_i` and `beat_o` becomes 0, both visible after that edge.
- R3: Bits above bit 1 of `addr_o` change only on a load edge; advancing never alters them.
- R4: With `order_i` = 0 (linear), after k advances `addr_o[1:0]` equals (start + k) mod 4, where start is the loaded value of bits [1:0].
- R5: With `order_i` = 1 (interleaved), after k advances `addr_o[1:0]` equals start XOR (k mod 4).
- R6: The fourth advance returns `addr_o` to the loaded address, and `beat_o` goes 3 -> 0, so the four-address cycle repeats.
- R7: On a load edge the state of `adv_n_i` is ignored: `beat_o` is 0 after the edge even with `adv_n_i` low.
- R8: On an edge with no load and `adv_n_i` high, `addr_o` and `beat_o` keep their values.
- R9: On an edge with no load and `adv_n_i` low, `beat_o` increments by one modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_a_i | input | 1 | First load strobe, active high |
| load_b_i | input | 1 | Second load strobe, active high |
| adv_n_i | input | 1 | Advance, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| ext_addr_i | input | ADDR_W | External starting address |
| addr_o | output | ADDR_W | Current access address |
| beat_o | output | 2 | Beat index within the burst |

## Verification
The bench builds the block with an 8-bit address. At that width every one of the 256 possible starting addresses can be loaded in both burst orders. Each load then runs a full walk of five advances, with a hold cycle before each advance. This covers every starting offset under both order rules and the wrap back to the start. It also covers every upper-bit pattern that must stay frozen. Each load is issued with advance low, and the loads rotate through the first strobe, the second strobe and both together. This exercises the load-over-advance priority and both load paths.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int OFS_W = 2;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } act_e;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        ofs_t start;
        ofs_t beat;
    } walk_t;

    function automatic ofs_t burst_offset(input walk_t w, input order_e ord);
        ofs_t r;
        if (ord == ORDER_XOR) r = w.start ^ w.beat;
        else                  r = w.start + w.beat;
        return r;
    endfunction

endpackage

// File: rtl/bag_ctl.sv
module bag_ctl
    import bag_pkg::*;
(
    input  logic load_a_i,
    input  logic load_b_i,
    input  logic adv_n_i,
    output act_e act_o
);
    always_comb begin
        if (load_a_i || load_b_i) act_o = ACT_LOAD;
        else if (!adv_n_i)        act_o = ACT_STEP;
        else                      act_o = ACT_HOLD;
    end
endmodule

// File: rtl/bag_beat_cnt.sv
module bag_beat_cnt
    import bag_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  act_e act_i,
    output ofs_t beat_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)                  beat_o <= '0;
        else if (act_i == ACT_LOAD) beat_o <= '0;
        else if (act_i == ACT_STEP) beat_o <= beat_o + ofs_t'(1);
    end

    // R9: a step moves the beat by one, wrapping modulo 4
    p_step_inc_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_i == ACT_STEP) |=> (beat_o == ofs_t'($past(beat_o) + 1)));
    // R7: a load clears the beat whatever advance does
    p_load_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_i == ACT_LOAD) |=> (beat_o == '0));
endmodule

// File: rtl/bag_base_reg.sv
module bag_base_reg
    import bag_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  act_e              act_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] base_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)                  base_o <= '0;
        else if (act_i == ACT_LOAD) base_o <= ext_addr_i;
    end

    // R3: the captured address is frozen outside load edges
    p_base_frozen_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_i != ACT_LOAD) |=> $stable(base_o));
endmodule

// File: rtl/bag_ofs_map.sv
module bag_ofs_map
    import bag_pkg::*;
(
    input  ofs_t start_i,
    input  ofs_t beat_i,
    input  logic order_i,
    output ofs_t ofs_o
);
    walk_t w;
    always_comb begin
        w.start = start_i;
        w.beat  = beat_i;
        ofs_o   = burst_offset(w, order_e'(order_i));
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_a_i,
    input  logic              load_b_i,
    input  logic              adv_n_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        beat_o
);
    localparam int HI_W = ADDR_W - OFS_W;

    act_e              act;
    ofs_t              beat;
    ofs_t              ofs;
    logic [ADDR_W-1:0] base;

    bag_ctl u_ctl (
        .load_a_i (load_a_i),
        .load_b_i (load_b_i),
        .adv_n_i  (adv_n_i),
        .act_o    (act)
    );

    bag_beat_cnt u_beat (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .act_i  (act),
        .beat_o (beat)
    );

    bag_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .act_i      (act),
        .ext_addr_i (ext_addr_i),
        .base_o     (base)
    );

    bag_ofs_map u_map (
        .start_i (base[OFS_W-1:0]),
        .beat_i  (beat),
        .order_i (order_i),
        .ofs_o   (ofs)
    );

    assign addr_o = {base[ADDR_W-1:OFS_W], ofs};
    assign beat_o = beat;

    // R8: no load and advance high keeps the address and beat
    p_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_a_i && !load_b_i && adv_n_i) |=> ($stable(addr_o) && $stable(beat_o)));
    // R2: a load presents the external address on the next cycle
    p_load_addr_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_a_i || load_b_i) |=> (addr_o == $past(ext_addr_i)));
    // R3: upper bits never move without a load
    p_upper_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_a_i && !load_b_i) |=> $stable(addr_o[ADDR_W-1:OFS_W]));
    // R6: the step from beat 3 lands on the start offset again
    p_wrap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_a_i && !load_b_i && !adv_n_i && beat_o == 2'd3 && $stable(order_i))
        |=> (addr_o[OFS_W-1:0] == base[OFS_W-1:0]));

    initial begin
        assert (HI_W >= 1) else $error("ADDR_W must exceed the offset width");
    end
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_a, load_b, adv_n, order;
    logic [AW-1:0] ext;
    logic [AW-1:0] addr;
    logic [1:0]    beat;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
        .clk_i      (clk),
        .rst_i      (rst),
        .load_a_i   (load_a),
        .load_b_i   (load_b),
        .adv_n_i    (adv_n),
        .order_i    (order),
        .ext_addr_i (ext),
        .addr_o     (addr),
        .beat_o     (beat)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [AW-1:0] exp_a,
                         input logic [1:0] exp_b);
        checks++;
        if (addr !== exp_a || beat !== exp_b) begin
            fails++;
            $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, addr, beat, exp_a, exp_b);
        end
    endtask

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] a,
                                                  input int k, input logic o);
        logic [1:0] s, off;
        s = a[1:0];
        if (o) off = s ^ 2'(k % 4);
        else   off = 2'((s + k) % 4);
        return {a[AW-1:2], off};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int sel = 0;
        rst = 1; load_a = 0; load_b = 0; adv_n = 0; order = 0; ext = '1;
        tick(); tick();
        check("R1 reset", '0, 2'd0);
        rst = 0;
        for (int m = 0; m < 2; m++) begin
            order = m[0];
            for (int a = 0; a < 256; a++) begin
                ext    = AW'(a);
                adv_n  = 0;
                load_a = (sel != 1);
                load_b = (sel != 0);
                sel    = (sel + 1) % 3;
                tick();
                load_a = 0; load_b = 0; ext = ~AW'(a);
                check("R2 R7 load with advance low", AW'(a), 2'd0);
                for (int k = 1; k <= 5; k++) begin
                    adv_n = 1;
                    tick();
                    check("R8 hold", expect_addr(AW'(a), k - 1, order), 2'((k - 1) % 4));
                    adv_n = 0;
                    tick();
                    if (k == 4)
                        check("R6 wrap to start", AW'(a), 2'd0);
                    else if (order)
                        check("R5 R3 R9 interleaved step", expect_addr(AW'(a), k, 1'b1), 2'(k % 4));
                    else
                        check("R4 R3 R9 linear step", expect_addr(AW'(a), k, 1'b0), 2'(k % 4));
                end
            end
        end
        rst = 1; adv_n = 1;
        tick();
        rst = 0;
        check("R1 reset after traffic", '0, 2'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule